// File: doc/BRIEF.md
# Masked Hardware Breakpoint Comparator

This block watches the instruction-fetch port and the data-access port of a processor and raises a one-cycle hit pulse when an access matches a programmed breakpoint. There are two breakpoint units. Each unit holds an address value and an ignore mask, a data value and an ignore mask, and an 8-bit control word with its own 8-bit ignore mask. A set mask bit means that bit takes no part in the comparison. A field matches when `((observed ^ value) & ~mask) == 0`.

The control word describes the access that is being watched. Bit 0 is the direction (1 write, 0 read). Bits 2:1 are the size (00 byte, 01 word, 10 dword, 11 reserved). Bit 3 picks the port (1 data access, 0 instruction fetch). Bit 4 is the FIQ-mode state. Bit 5 is the IRQ-mode state. On unit 0 only, bit 6 chains unit 0 behind unit 1, and bit 7 turns unit 0's address compare into a closed range whose upper bound is unit 1's address value. A fetch is seen as a read of size 10. Each unit also keeps a flag that says whether its most recent hit was a load.

Registers are written through a simple port. Select codes: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control, 5 control mask.

Top module: `bkpt_compare_pair`

## Requirements
- R1: While reset is low, and on the first cycle after it, `hit` and `hit_load` are 00. Every register resets to zero, and with reset contents no access produces a hit.
- R2: A unit whose control bit 3 is 0 compares `fetch_addr` against its address value under its address mask whenever `fetch_valid` is high. A match sets `hit[i]` for exactly the cycle after the access.
- R3: The data value and data mask are compared with `acc_data` only when control bit 3 is 1. A unit watching fetches ignores them.
- R4: The observed attributes are compared with control bits 5:0 under control-mask bits 5:0. The attributes are: write in bit 0, size in bits 2:1, port in bit 3, `cpu_fiq` in bit 4 and `cpu_irq` in bit 5. A fetch presents write 0 and size 10.
- R5: A size of 11 never matches. This holds when the programmed size is 11 or the data access size is 11, even if the size bits are masked.
- R6: When unit 0 control bit 6 is set, unit 0 hits only if unit 1 matched on an earlier cycle. A match by unit 1 in the same cycle does not count. The armed state stays set until reset or any write to a unit 0 register.
- R7: When unit 0 control bit 7 is set, unit 0's address matches when the address is at least unit 0's address value and at most unit 1's address value. The address mask is not used. All other fields still apply.
- R8: On each hit, `hit_load[i]` is updated at the same edge as `hit[i]`. It becomes 1 for a data read and 0 for a data write or a fetch. Without a hit, it holds its value.
- R9: The two units compare independently and can hit in the same cycle. On unit 1, control bits 7:6 are reserved: they store as 0 and have no effect.
- R10: A register write takes effect on the cycle after it. An access in the same cycle as a write is compared against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | 1 | Target unit of the write |
| cfg_sel | input | 3 | Register select code (0..5) |
| cfg_wdata | input | CFG_W | Write data |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| acc_valid | input | 1 | Data access this cycle |
| acc_addr | input | ADDR_W | Data access address |
| acc_data | input | DATA_W | Data moved by the access |
| acc_size | input | 2 | Access size code |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| cpu_fiq | input | 1 | Processor is in FIQ mode |
| cpu_irq | input | 1 | Processor is in IRQ mode |
| hit | output | 2 | Per-unit registered match pulse |
| hit_load | output | 2 | Per-unit flag: last hit was a load |

## Verification
Two pairs of functions can fall in the same cycle.

- **Fetch and data hits together.** A fetch and a data access are applied in one cycle, each matching a different unit. The bench expects `hit` to be 11. It also expects `hit_load` to take a 0 for the fetch unit and a 1 for the data unit at the same edge.
- **Chain arming and unit 0's compare.** With chaining on, unit 1's trigger and unit 0's matching fetch arrive in the same cycle. The bench expects only unit 1 to hit. On the following fetch, unit 0 is expected to hit, because the arming now comes from an earlier cycle.

A register write in the same cycle as a matching access is judged against the old contents.

// File: rtl/bkpt_pkg.sv
// Shared constants for the breakpoint comparator: register select codes
// and the bit positions of the control word.
package bkpt_pkg;
    localparam int NUM_UNITS = 2;
    localparam int CTRL_W    = 8;

    typedef enum logic [2:0] {
        SEL_ADDR_VAL = 3'd0,
        SEL_ADDR_MSK = 3'd1,
        SEL_DATA_VAL = 3'd2,
        SEL_DATA_MSK = 3'd3,
        SEL_CTRL     = 3'd4,
        SEL_CTRL_MSK = 3'd5
    } cfg_sel_e;

    localparam int CB_WRITE = 0;
    localparam int CB_SZ_LO = 1;
    localparam int CB_SZ_HI = 2;
    localparam int CB_DATA  = 3;
    localparam int CB_FIQ   = 4;
    localparam int CB_IRQ   = 5;
    localparam int CB_CHAIN = 6;
    localparam int CB_RANGE = 7;

    localparam logic [1:0] SIZE_RSVD  = 2'b11;
    localparam logic [1:0] FETCH_SIZE = 2'b10;
endpackage

// File: rtl/bkpt_unit_regs.sv
// Register set of one breakpoint unit.
// Assumes a single-cycle write strobe. UNIT_IDX selects whether the
// link bits (chain/range) are kept or forced to zero as reserved.
module bkpt_unit_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CFG_W    = 32,
    parameter int UNIT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [CFG_W-1:0]  wdata,
    output logic [ADDR_W-1:0] addr_val,
    output logic [ADDR_W-1:0] addr_msk,
    output logic [DATA_W-1:0] data_val,
    output logic [DATA_W-1:0] data_msk,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CTRL_W-1:0] ctrl_msk
);
    // Only unit 0 keeps the link bits.
    localparam logic [CTRL_W-1:0] CTRL_KEEP = (UNIT_IDX == 0) ? 8'hFF : 8'h3F;

    // Write the selected register; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_val <= '0;
            addr_msk <= '0;
            data_val <= '0;
            data_msk <= '0;
            ctrl     <= '0;
            ctrl_msk <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ADDR_VAL: addr_val <= wdata[ADDR_W-1:0];
                SEL_ADDR_MSK: addr_msk <= wdata[ADDR_W-1:0];
                SEL_DATA_VAL: data_val <= wdata[DATA_W-1:0];
                SEL_DATA_MSK: data_msk <= wdata[DATA_W-1:0];
                SEL_CTRL:     ctrl     <= wdata[CTRL_W-1:0] & CTRL_KEEP;
                SEL_CTRL_MSK: ctrl_msk <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bkpt_unit_match.sv
// Combinational compare of one unit against the current access.
// Assumes fetch and data ports are sampled in the same cycle. Range mode
// replaces the masked address compare with an inclusive bound check.
module bkpt_unit_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] addr_msk,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] data_msk,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CTRL_W-1:0] ctrl_msk,
    input  logic              range_en,
    input  logic [ADDR_W-1:0] range_hi,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              cpu_fiq,
    input  logic              cpu_irq,
    output logic              raw_match,
    output logic              is_load
);
    logic              use_data;
    logic              port_valid;
    logic [ADDR_W-1:0] obs_addr;
    logic [CTRL_W-1:0] obs_attr;
    logic              addr_ok, data_ok, ctrl_ok, size_bad;

    // Pick the watched port and build the observed attribute byte.
    always_comb begin
        use_data   = ctrl[CB_DATA];
        port_valid = use_data ? acc_valid : fetch_valid;
        obs_addr   = use_data ? acc_addr : fetch_addr;
        obs_attr   = {ctrl[CB_RANGE:CB_CHAIN], cpu_irq, cpu_fiq, use_data,
                      (use_data ? acc_size : FETCH_SIZE),
                      (use_data & acc_write)};
    end

    // Evaluate each field under its ignore mask.
    always_comb begin
        if (range_en)
            addr_ok = (obs_addr >= addr_val) && (obs_addr <= range_hi);
        else
            addr_ok = ((obs_addr ^ addr_val) & ~addr_msk) == '0;
        data_ok   = !use_data || (((acc_data ^ data_val) & ~data_msk) == '0);
        ctrl_ok   = ((obs_attr ^ ctrl) & ~ctrl_msk) == '0;
        size_bad  = (ctrl[CB_SZ_HI:CB_SZ_LO] == SIZE_RSVD) ||
                    (use_data && acc_size == SIZE_RSVD);
        raw_match = port_valid && addr_ok && data_ok && ctrl_ok && !size_bad;
        is_load   = use_data && !acc_write;
    end
endmodule

// File: rtl/bkpt_compare_pair.sv
// Two-unit masked breakpoint comparator.
// Holds both register sets and compares every cycle. Unit 0 can be chained
// behind unit 1 or can take its upper address bound from unit 1.
// Hits and the load flag are registered. Assumes synchronous active-low reset.
module bkpt_compare_pair
    import bkpt_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int CFG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_unit,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              cpu_fiq,
    input  logic              cpu_irq,
    output logic [1:0]        hit,
    output logic [1:0]        hit_load
);
    logic [NUM_UNITS-1:0][ADDR_W-1:0] u_addr_val, u_addr_msk;
    logic [NUM_UNITS-1:0][DATA_W-1:0] u_data_val, u_data_msk;
    logic [NUM_UNITS-1:0][CTRL_W-1:0] u_ctrl, u_ctrl_msk;
    logic [NUM_UNITS-1:0]             u_raw, u_load, u_final;
    logic                             chain_armed_q;
    logic [1:0]                       hit_q, hit_load_q;

    for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
        bkpt_unit_regs #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .UNIT_IDX(gi)
        ) regs_i (
            .clk(clk), .rst_n(rst_n),
            .we(cfg_we && (cfg_unit == gi[0])),
            .sel(cfg_sel), .wdata(cfg_wdata),
            .addr_val(u_addr_val[gi]), .addr_msk(u_addr_msk[gi]),
            .data_val(u_data_val[gi]), .data_msk(u_data_msk[gi]),
            .ctrl(u_ctrl[gi]), .ctrl_msk(u_ctrl_msk[gi])
        );

        bkpt_unit_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
            .addr_val(u_addr_val[gi]), .addr_msk(u_addr_msk[gi]),
            .data_val(u_data_val[gi]), .data_msk(u_data_msk[gi]),
            .ctrl(u_ctrl[gi]), .ctrl_msk(u_ctrl_msk[gi]),
            .range_en((gi == 0) ? u_ctrl[0][CB_RANGE] : 1'b0),
            .range_hi(u_addr_val[NUM_UNITS-1]),
            .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
            .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
            .acc_size(acc_size), .acc_write(acc_write),
            .cpu_fiq(cpu_fiq), .cpu_irq(cpu_irq),
            .raw_match(u_raw[gi]), .is_load(u_load[gi])
        );
    end

    // Gate unit 0 by the chain arming; unit 1 reports its raw compare.
    always_comb begin
        u_final[0] = u_raw[0] && (!u_ctrl[0][CB_CHAIN] || chain_armed_q);
        u_final[1] = u_raw[1];
    end

    // Arm on a unit 1 match; disarm on reset or any unit 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_armed_q <= 1'b0;
        else if (cfg_we && cfg_unit == 1'b0)
            chain_armed_q <= 1'b0;
        else if (u_raw[1])
            chain_armed_q <= 1'b1;
    end

    // Register the hit pulses and capture the load flag on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q      <= '0;
            hit_load_q <= '0;
        end else begin
            hit_q <= u_final;
            for (int i = 0; i < NUM_UNITS; i++)
                if (u_final[i]) hit_load_q[i] <= u_load[i];
        end
    end

    assign hit      = hit_q;
    assign hit_load = hit_load_q;
endmodule

// File: rtl/bkpt_compare_pair_chk.sv
// Property checker for bkpt_compare_pair, attached by bind below.
module bkpt_compare_pair_chk
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             fetch_valid,
    input logic [ADDR_W-1:0]                fetch_addr,
    input logic                             acc_valid,
    input logic [ADDR_W-1:0]                acc_addr,
    input logic [1:0]                       hit,
    input logic [1:0]                       hit_load,
    input logic [NUM_UNITS-1:0][CTRL_W-1:0] u_ctrl,
    input logic [NUM_UNITS-1:0][ADDR_W-1:0] u_addr_val,
    input logic                             chain_armed_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (hit == 2'b00 && hit_load == 2'b00));

    for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_chk
        assert_hit_needs_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hit[gi] |-> $past(u_ctrl[gi][CB_DATA] ? acc_valid : fetch_valid));

        assert_no_reserved_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hit[gi] |-> ($past(u_ctrl[gi][CB_SZ_HI:CB_SZ_LO]) != SIZE_RSVD));

        assert_load_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[gi] |-> $stable(hit_load[gi]));

        assert_fetch_not_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[gi] && !$past(u_ctrl[gi][CB_DATA])) |-> !hit_load[gi]);
    end

    assert_chain_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && $past(u_ctrl[0][CB_CHAIN])) |-> $past(chain_armed_q));

    assert_range_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && $past(u_ctrl[0][CB_RANGE]) && !$past(u_ctrl[0][CB_DATA])) |->
        ($past(fetch_addr) >= $past(u_addr_val[0]) &&
         $past(fetch_addr) <= $past(u_addr_val[1])));

    assert_unit1_link_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        u_ctrl[1][CB_RANGE:CB_CHAIN] == 2'b00);
endmodule

bind bkpt_compare_pair bkpt_compare_pair_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .hit(hit), .hit_load(hit_load),
    .u_ctrl(u_ctrl), .u_addr_val(u_addr_val),
    .chain_armed_q(chain_armed_q)
);

// File: tb/bkpt_compare_pair_tb_top.sv
// Bench for bkpt_compare_pair: a vector table, then directed cases.
module bkpt_compare_pair_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {fv, faddr, av, aaddr, adata, size, write, fiq, irq, exp_hit, exp_load}
    localparam logic [106:0] VEC [NV] = '{
        {1'b1, 32'h1004, 1'b0, 32'h0,    32'h0,        2'b00, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00},
        {1'b1, 32'h1010, 1'b0, 32'h0,    32'h0,        2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
        {1'b0, 32'h0,    1'b1, 32'h2000, 32'h123456AB, 2'b01, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10},
        {1'b0, 32'h0,    1'b1, 32'h2000, 32'h123456AB, 2'b01, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10},
        {1'b0, 32'h0,    1'b1, 32'h2000, 32'h123456AB, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10},
        {1'b0, 32'h0,    1'b1, 32'h2000, 32'h123456AC, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10},
        {1'b1, 32'h100F, 1'b1, 32'h2000, 32'h000000AB, 2'b01, 1'b0, 1'b1, 1'b0, 2'b11, 2'b10},
        {1'b0, 32'h0,    1'b1, 32'h2001, 32'h000000AB, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_unit = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fetch_valid = 1'b0, acc_valid = 1'b0;
    logic [31:0] fetch_addr = '0, acc_addr = '0, acc_data = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0, cpu_fiq = 1'b0, cpu_irq = 1'b0;
    logic [1:0]  hit, hit_load;
    int          n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_compare_pair dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
        .acc_size(acc_size), .acc_write(acc_write),
        .cpu_fiq(cpu_fiq), .cpu_irq(cpu_irq),
        .hit(hit), .hit_load(hit_load)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cfg(input logic unit, input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_unit = unit; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one access for one cycle; outputs are valid at the next negedge.
    task automatic step(input logic fv, input logic [31:0] fa, input logic av,
                        input logic [31:0] aa, input logic [31:0] ad,
                        input logic [1:0] sz, input logic wr,
                        input logic fq, input logic iq);
        fetch_valid = fv; fetch_addr = fa; acc_valid = av; acc_addr = aa;
        acc_data = ad; acc_size = sz; acc_write = wr; cpu_fiq = fq; cpu_irq = iq;
        @(negedge clk);
        fetch_valid = 1'b0; acc_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a);
        step(1'b1, a, 1'b0, 32'h0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input logic wr, input logic fq, input logic iq);
        step(1'b0, 32'h0, 1'b1, a, d, sz, wr, fq, iq);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hit in reset", hit, 2'b00);
        check("R1 hit_load in reset", hit_load, 2'b00);
        rst_n = 1'b1;
        fetch(32'h0);
        check("R1 reset contents match nothing", hit, 2'b00);

        // unit 0: fetch 0x100x; unit 1: word reads at 0x2000, low byte AB
        cfg(1'b0, 3'd0, 32'h1000); cfg(1'b0, 3'd1, 32'h000F);
        cfg(1'b0, 3'd4, 32'h04);   cfg(1'b0, 3'd5, 32'h30);
        cfg(1'b1, 3'd0, 32'h2000); cfg(1'b1, 3'd1, 32'h0);
        cfg(1'b1, 3'd2, 32'hAB);   cfg(1'b1, 3'd3, 32'hFFFFFF00);
        cfg(1'b1, 3'd4, 32'h0A);   cfg(1'b1, 3'd5, 32'h30);

        for (int k = 0; k < NV; k++) begin
            logic [106:0] v;
            v = VEC[k];
            step(v[106], v[105:74], v[73], v[72:41], v[40:9], v[8:7], v[6], v[5], v[4]);
            check($sformatf("R2/R3/R4/R9 vector %0d hit", k), hit, v[3:2]);
            check($sformatf("R8 vector %0d hit_load", k), hit_load, v[1:0]);
        end

        // R3: data fields ignored by a fetch unit
        cfg(1'b0, 3'd2, 32'hDEAD); cfg(1'b0, 3'd3, 32'h0);
        fetch(32'h1000);
        check("R3 fetch unit ignores data fields", hit, 2'b01);
        check("R8 fetch hit clears load flag", hit_load, 2'b10);

        // R4: mode bits compared when unmasked
        cfg(1'b1, 3'd5, 32'h00);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b1);
        check("R4 irq mismatch", hit, 2'b00);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R4 modes clear match", hit, 2'b10);
        cfg(1'b1, 3'd4, 32'h1A); cfg(1'b1, 3'd5, 32'h20);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b1, 1'b0);
        check("R4 fiq required present", hit, 2'b10);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R4 fiq required absent", hit, 2'b00);
        cfg(1'b1, 3'd5, 32'h21);
        rd(32'h2000, 32'hAB, 2'b01, 1'b1, 1'b1, 1'b0);
        check("R4 direction masked", hit, 2'b10);
        check("R8 write hit clears load flag", hit_load, 2'b00);

        // R5: reserved size never matches
        cfg(1'b1, 3'd4, 32'h0E); cfg(1'b1, 3'd5, 32'h36);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R5 programmed size 11", hit, 2'b00);
        cfg(1'b1, 3'd4, 32'hCA);
        rd(32'h2000, 32'hAB, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R5 access size 11", hit, 2'b00);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R9 unit1 link bits reserved, hits unchained", hit, 2'b10);
        check("R8 read hit sets load flag", hit_load, 2'b10);

        // R6: chain
        cfg(1'b0, 3'd4, 32'h44);
        fetch(32'h1000);
        check("R6 chain not armed", hit, 2'b00);
        rd(32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R6 unit1 arms", hit, 2'b10);
        fetch(32'h1000);
        check("R6 armed fetch hits", hit, 2'b01);
        fetch(32'h1000);
        check("R6 arming sticky", hit, 2'b01);
        cfg(1'b0, 3'd4, 32'h44);
        fetch(32'h1000);
        check("R6 rewrite disarms", hit, 2'b00);
        step(1'b1, 32'h1000, 1'b1, 32'h2000, 32'hAB, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R6 same-cycle arming not counted", hit, 2'b10);
        fetch(32'h1000);
        check("R6 next fetch after arming", hit, 2'b01);

        // R7: range 0x3000..0x30FF
        cfg(1'b0, 3'd4, 32'h84); cfg(1'b0, 3'd0, 32'h3000); cfg(1'b1, 3'd0, 32'h30FF);
        fetch(32'h2FFF); check("R7 below range", hit, 2'b00);
        fetch(32'h3000); check("R7 low bound", hit, 2'b01);
        fetch(32'h3080); check("R7 inside", hit, 2'b01);
        fetch(32'h30FF); check("R7 high bound", hit, 2'b01);
        fetch(32'h3100); check("R7 above range", hit, 2'b00);

        // R10: write and access in the same cycle
        cfg(1'b0, 3'd4, 32'h04); cfg(1'b0, 3'd0, 32'h1000);
        cfg_we = 1'b1; cfg_unit = 1'b0; cfg_sel = 3'd0; cfg_wdata = 32'h5000;
        fetch(32'h1000);
        check("R10 same-cycle write uses old value", hit, 2'b01);
        fetch(32'h1000);
        check("R10 old address gone", hit, 2'b00);
        fetch(32'h5004);
        check("R10 new address active", hit, 2'b01);

        summary();
        $finish;
    end
endmodule